// File: doc/BRIEF.md
# Reset and Clock-Start Sequencer

This block runs on the reference clock and brings a processor clock system out of reset in a fixed, checkable order. It watches an active-low external reset. The reset counts as valid only once it has stayed low for a minimum number of consecutive reference edges. While that reset is low the block keeps capturing an 8-bit configuration word, so the value it holds is the one seen on the last low edge. The low three bits of that word pick the ratio of the bus clock.

When the reset input releases, the block waits for a modelled lock interval with every derived clock held low. It then starts the divided bus clock while still holding its active-low reset output to downstream logic, so that peripherals see a running clock during reset. After a further hold period it releases that reset output. A set number of cycles later it starts the trace clock, which runs at half the processor rate. In this model the processor clock is the reference clock itself, so lock is a cycle count and both divisions are counted on the reference clock.

If the reset input drops again at any point, the sequence aborts. A new sequence needs a fresh valid reset.

Top module: `clkrst_seq`

## Requirements
- R1: A low phase of `ext_rst_n` shorter than QUAL_CYCLES (16) consecutive edges starts no sequence: after it releases, `rst_out_n`, `bus_clk` and `trace_clk` stay 0 and `lock_done` keeps its value.
- R2: `cfg_q` takes the value of `cfg_in` on every edge that samples `ext_rst_n` low and holds it while `ext_rst_n` is high, so it holds the value present on the last low edge before release.
- R3: A captured field `cfg_q[2:0]` of 3, 4, 5 or 6 gives `div_ratio` equal to that code and `cfg_bad` = 0.
- R4: Any other field code (0, 1, 2, 7) gives `div_ratio` = 4 and `cfg_bad` = 1. After reset `div_ratio` = 4 and `cfg_bad` = 0.
- R5: Let E0 be the first edge that samples `ext_rst_n` high after a valid reset. Through edge E0+LOCK_CYCLES-1, `bus_clk`, `trace_clk`, `rst_out_n` and `lock_done` are 0. On edge E0+LOCK_CYCLES, `lock_done` becomes 1.
- R6: From edge E0+LOCK_CYCLES, `bus_clk` follows `(k mod N) < N/2`, where k counts edges from that edge and N is `div_ratio` (integer division, so the clock starts high).
- R7: `rst_out_n` rises on edge E0+LOCK_CYCLES+RSTO_HOLD, and is never high while `lock_done` is 0 at that rise.
- R8: `trace_clk` first goes high TRACE_DELAY (10) edges after `rst_out_n` rises. It then inverts on every edge, and it is 0 whenever `rst_out_n` is 0.
- R9: `ext_rst_n` sampled low in the lock, hold or run phases drives `rst_out_n`, `bus_clk` and `trace_clk` to 0 on that same edge, and leaves `lock_done` unchanged.
- R10: `lock_done` clears on the QUAL_CYCLES-th consecutive edge that samples `ext_rst_n` low, and not before.
- R11: While the synchronous `rst` is high, all outputs are 0 except `div_ratio` = 4, and no sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the modelled processor clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External reset request, active low |
| cfg_in | input | 8 | Configuration word; bits [2:0] select the bus ratio |
| rst_out_n | output | 1 | Reset to downstream peripherals, active low |
| bus_clk | output | 1 | Divided bus clock |
| trace_clk | output | 1 | Trace clock at half the processor rate |
| cfg_q | output | 8 | Captured configuration word |
| div_ratio | output | 3 | Bus division ratio in use |
| cfg_bad | output | 1 | Captured ratio code was unsupported |
| lock_done | output | 1 | Lock interval has completed since the last valid reset |

## Verification
Every output is registered. An abort, the capture of `cfg_q` and the clearing of `lock_done` are therefore visible after the same edge that samples the input, and `lock_done` and the first high phase of `bus_clk` appear after edge E0+LOCK_CYCLES. `rst_out_n` follows RSTO_HOLD edges later and the first high phase of `trace_clk` TRACE_DELAY edges after that. The bench drives inputs and samples outputs on falling edges only. It counts rising edges from the release with tick calls, so every check lands on the last edge before a change and on the first edge after it. The lock and hold intervals are shortened by parameter override so that all ratio codes fit in one run.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

  typedef enum logic [2:0] {
    ST_QUAL,
    ST_ARMED,
    ST_LOCK,
    ST_HOLD,
    ST_RWAIT,
    ST_RUN
  } seq_state_t;

  // Returns {bad, ratio}; unsupported codes fall back to a ratio of 4.
  function automatic logic [3:0] decode_ratio(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      3'd3, 3'd4, 3'd5, 3'd6: r = {1'b0, code};
      default:                r = {1'b1, 3'd4};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_n,
  output logic qual_hit
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);

  logic [QW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || ext_rst_n) begin
      low_cnt <= '0;
    end else if (low_cnt != QW'(QUAL_CYCLES)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign qual_hit = !ext_rst_n && (low_cnt == QW'(QUAL_CYCLES - 1));
endmodule

// File: rtl/cfg_capture.sv
module cfg_capture #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] cfg_q,
  output logic [2:0]       ratio,
  output logic             bad
);
  import clkrst_pkg::*;

  logic [3:0] dec;
  assign dec = decode_ratio(cfg_in[2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ratio <= 3'd4;
      bad   <= 1'b0;
    end else if (load) begin
      cfg_q <= cfg_in;
      ratio <= dec[2:0];
      bad   <= dec[3];
    end
  end
endmodule

// File: rtl/clk_divgen.sv
module clk_divgen (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] ratio,
  input  logic       bus_start,
  input  logic       bus_run,
  input  logic       trace_run,
  output logic       bus_clk,
  output logic       trace_clk
);
  logic [2:0] phase;
  logic [2:0] phase_nx;
  logic [2:0] half;

  assign half     = ratio >> 1;
  assign phase_nx = (phase == ratio - 3'd1) ? 3'd0 : phase + 3'd1;

  always_ff @(posedge clk) begin
    if (rst || !bus_run) begin
      phase   <= 3'd0;
      bus_clk <= 1'b0;
    end else if (bus_start) begin
      phase   <= 3'd0;
      bus_clk <= 1'b1;
    end else begin
      phase   <= phase_nx;
      bus_clk <= (phase_nx < half);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !trace_run) trace_clk <= 1'b0;
    else                   trace_clk <= ~trace_clk;
  end
endmodule

// File: rtl/clkrst_seq.sv
module clkrst_seq #(
  parameter int QUAL_CYCLES = 16,
  parameter int LOCK_CYCLES = 50000,
  parameter int RSTO_HOLD   = 1024,
  parameter int TRACE_DELAY = 10,
  parameter int CFG_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_n,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             rst_out_n,
  output logic             bus_clk,
  output logic             trace_clk,
  output logic [CFG_W-1:0] cfg_q,
  output logic [2:0]       div_ratio,
  output logic             cfg_bad,
  output logic             lock_done
);
  import clkrst_pkg::*;

  localparam int MAX_A = (LOCK_CYCLES > RSTO_HOLD) ? LOCK_CYCLES : RSTO_HOLD;
  localparam int MAX_W = (MAX_A > TRACE_DELAY) ? MAX_A : TRACE_DELAY;
  localparam int CW    = $clog2(MAX_W + 1);

  seq_state_t    state, nxt;
  logic [CW-1:0] cnt;
  logic          qual_hit;
  logic          bus_start, bus_run, trace_run;

  rst_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .qual_hit(qual_hit)
  );

  cfg_capture #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .load(!ext_rst_n), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .ratio(div_ratio), .bad(cfg_bad)
  );

  always_comb begin
    nxt = state;
    if (qual_hit) begin
      nxt = ST_ARMED;
    end else if (!ext_rst_n && state != ST_ARMED) begin
      nxt = ST_QUAL;
    end else begin
      case (state)
        ST_ARMED: if (ext_rst_n) nxt = ST_LOCK;
        ST_LOCK:  if (cnt == CW'(LOCK_CYCLES - 1)) nxt = ST_HOLD;
        ST_HOLD:  if (cnt == CW'(RSTO_HOLD - 1))   nxt = ST_RWAIT;
        ST_RWAIT: if (cnt == CW'(TRACE_DELAY - 1)) nxt = ST_RUN;
        default:  nxt = state;
      endcase
    end
  end

  assign bus_start = (state == ST_LOCK) && (nxt == ST_HOLD);
  assign bus_run   = (nxt == ST_HOLD) || (nxt == ST_RWAIT) || (nxt == ST_RUN);
  assign trace_run = (nxt == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_QUAL;
      cnt       <= '0;
      rst_out_n <= 1'b0;
      lock_done <= 1'b0;
    end else begin
      state     <= nxt;
      rst_out_n <= (nxt == ST_RWAIT) || (nxt == ST_RUN);
      if (nxt != state)
        cnt <= '0;
      else if (state == ST_LOCK || state == ST_HOLD || state == ST_RWAIT)
        cnt <= cnt + 1'b1;
      if (qual_hit)
        lock_done <= 1'b0;
      else if (bus_start)
        lock_done <= 1'b1;
    end
  end

  clk_divgen u_div (
    .clk(clk), .rst(rst), .ratio(div_ratio),
    .bus_start(bus_start), .bus_run(bus_run), .trace_run(trace_run),
    .bus_clk(bus_clk), .trace_clk(trace_clk)
  );
endmodule

// File: rtl/clkrst_seq_chk.sv
module clkrst_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_rst_n,
  input logic       rst_out_n,
  input logic       bus_clk,
  input logic       trace_clk,
  input logic [7:0] cfg_q,
  input logic       lock_done
);
  AST_TRACE_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !rst_out_n |-> !trace_clk);                                   // R8
  AST_TRACE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    trace_clk |=> !trace_clk);                                    // R8
  AST_BUS_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    bus_clk |-> lock_done);                                       // R5
  AST_RELEASE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> lock_done);                              // R7
  AST_LOCK_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_done) |-> !rst_out_n);                             // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(ext_rst_n) |-> $stable(cfg_q));                         // R2
endmodule

bind clkrst_seq clkrst_seq_chk u_chk (
  .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .rst_out_n(rst_out_n),
  .bus_clk(bus_clk), .trace_clk(trace_clk), .cfg_q(cfg_q), .lock_done(lock_done)
);

// File: tb/clkrst_seq_test.sv
module clkrst_seq_test;
  localparam int L = 200;
  localparam int H = 40;
  localparam int D = 10;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_rst_n = 1'b1;
  logic [7:0] cfg_in = 8'h00;
  logic       rst_out_n, bus_clk, trace_clk, cfg_bad, lock_done;
  logic [7:0] cfg_q;
  logic [2:0] div_ratio;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  clkrst_seq #(.QUAL_CYCLES(Q), .LOCK_CYCLES(L), .RSTO_HOLD(H), .TRACE_DELAY(D)) uut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .cfg_in(cfg_in),
    .rst_out_n(rst_out_n), .bus_clk(bus_clk), .trace_clk(trace_clk),
    .cfg_q(cfg_q), .div_ratio(div_ratio), .cfg_bad(cfg_bad), .lock_done(lock_done)
  );

  // {code, expected ratio, expected bad}
  localparam logic [6:0] VEC [0:6] = '{
    {3'd3, 3'd3, 1'b0}, {3'd4, 3'd4, 1'b0}, {3'd5, 3'd5, 1'b0},
    {3'd6, 3'd6, 1'b0}, {3'd0, 3'd4, 1'b1}, {3'd7, 3'd4, 1'b1},
    {3'd2, 3'd4, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Low phase of nlow edges; the word is only valid on the last low edge.
  task automatic pulse(input logic [7:0] word, input int nlow);
    ext_rst_n = 1'b0;
    cfg_in = 8'hA8;
    tick(nlow - 1);
    cfg_in = word;
    tick(1);
    ext_rst_n = 1'b1;
    cfg_in = 8'h55;
  endtask

  // Starts right after release; walks lock, hold and trace start.
  task automatic follow(input logic [7:0] word, input int n, input logic bad);
    tick(L);
    check("R5 lock_done in lock", {31'd0, lock_done}, 0);
    check("R5 bus low in lock", {31'd0, bus_clk}, 0);
    check("R5 rst_out in lock", {31'd0, rst_out_n}, 0);
    check("R2 cfg_q held", {24'd0, cfg_q}, {24'd0, word});
    check("R3 R4 div_ratio", {29'd0, div_ratio}, n);
    check("R3 R4 cfg_bad", {31'd0, cfg_bad}, {31'd0, bad});
    tick(1);
    check("R5 lock_done set", {31'd0, lock_done}, 1);
    for (int k = 0; k < 2 * n; k++) begin
      check("R6 bus waveform", {31'd0, bus_clk}, ((k % n) < (n / 2)) ? 1 : 0);
      tick(1);
    end
    tick(H - 1 - 2 * n);
    check("R7 rst_out before hold end", {31'd0, rst_out_n}, 0);
    check("R8 trace low in hold", {31'd0, trace_clk}, 0);
    tick(1);
    check("R7 rst_out released", {31'd0, rst_out_n}, 1);
    tick(D - 1);
    check("R8 trace before delay", {31'd0, trace_clk}, 0);
    tick(1);
    check("R8 trace first high", {31'd0, trace_clk}, 1);
    tick(1);
    check("R8 trace toggles", {31'd0, trace_clk}, 0);
    tick(1);
    check("R8 trace toggles again", {31'd0, trace_clk}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R11 rst_out in reset", {31'd0, rst_out_n}, 0);
    check("R11 ratio in reset", {29'd0, div_ratio}, 4);
    check("R11 lock_done in reset", {31'd0, lock_done}, 0);
    rst = 1'b0;
    tick(5);
    check("R11 idle after reset", {29'd0, bus_clk, trace_clk, rst_out_n}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [7:0] w;
      w = {5'(i * 3 + 1), VEC[i][6:4]};
      pulse(w, Q + i);
      follow(w, int'(VEC[i][3:1]), VEC[i][0]);
      tick(7);
    end

    // Abort while running; lock_done must survive a non-qualified low
    ext_rst_n = 1'b0;
    tick(1);
    check("R9 abort rst_out", {31'd0, rst_out_n}, 0);
    check("R9 abort bus", {31'd0, bus_clk}, 0);
    check("R9 abort trace", {31'd0, trace_clk}, 0);
    check("R9 lock_done kept", {31'd0, lock_done}, 1);
    tick(Q - 2);
    ext_rst_n = 1'b1;
    tick(L + H + D + 20);
    check("R1 short pulse no start", {29'd0, bus_clk, trace_clk, rst_out_n}, 0);
    check("R1 short pulse lock_done kept", {31'd0, lock_done}, 1);

    // Valid reset of exactly Q edges
    ext_rst_n = 1'b0;
    cfg_in = 8'h00;
    tick(Q - 1);
    check("R10 lock_done before qual", {31'd0, lock_done}, 1);
    cfg_in = 8'hC5;
    tick(1);
    check("R10 lock_done cleared", {31'd0, lock_done}, 0);
    ext_rst_n = 1'b1;
    cfg_in = 8'h12;
    follow(8'hC5, 5, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule